// File: doc/BRIEF.md
# Idle Standby and Wake Controller

This block puts a small processor subsystem into a low-power idle state and brings it back out. Software selects idle through a mode bit and then requests the stop. After a fixed five-cycle settling window, the block drops the clock enables to the CPU and to the peripherals fed by the main clock. The enable for the always-on peripheral domain stays high, and the main oscillator is never touched. Because the oscillator keeps running, release takes effect on the next clock edge with no stabilization wait.

While idle, the block watches a non-maskable request, seven external request lines and a set of internal peripheral requests. Each maskable request has its own mask and its own 3-bit priority. The block also receives the priority of the interrupt currently in service and the processor's interrupt-enable flag. Any unmasked request wakes the subsystem. Two separate questions are then answered: whether the waking request is acknowledged, and where execution resumes. The answer is reported for one cycle as an action code with a strobe, together with an acknowledge pulse and a source ID when the request is taken.

Top module: `idle_standby`

## Requirements
- R1: While and right after reset, `cpuClkEn` and `mainPeriClkEn` are 1, `idleActive` is 0, and `actStrobe` and `ackPulse` are 0.
- R2: A write of 1 to the stop bit while running normally and with the mode bit at 0 makes `idleActive` go to 1 and `cpuClkEn` and `mainPeriClkEn` go to 0 exactly five clock cycles after the write edge.
- R3: A stop write is ignored, and the block stays in normal mode, when the mode bit is 1 or when the written stop value is 0.
- R4: `auxPeriClkEn` is 1 at all times, including in idle.
- R5: Requests that arrive during the five-cycle settling window produce no action strobe and do not prevent entry into idle.
- R6: While idle, masked requests are ignored. The non-maskable request or any unmasked request restores both gated enables and clears `idleActive` on the next clock edge.
- R7: A non-maskable wake is always acknowledged, whatever the enable flag and in-service priority. It gives action code 1 (branch to handler) and `ackId` 15.
- R8: Among the unmasked requests, the winner has the lowest priority value; a tie goes to the lowest source ID. External line n has ID n (0 to 6), and internal request k has ID 7+k. With interrupts enabled and a winner more urgent than the in-service level (or nothing in service), the wake is acknowledged with code 1 and the winner's ID.
- R9: A maskable wake with interrupts disabled gives code 2 (next instruction) and no acknowledge pulse.
- R10: A maskable wake whose winner has a priority value greater than or equal to the in-service level gives code 2 and no acknowledge pulse, so the request stays pending.
- R11: `actStrobe` lasts exactly one cycle per wake. Whenever it is 0, `actCode` is 0 (none), `ackPulse` is 0 and `ackId` is 0.
- R12: Asserting reset while idle restores `cpuClkEn` and `mainPeriClkEn` at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSelWr | input | 1 | Write strobe for the mode-select bit |
| modeSelData | input | 1 | Mode-select value (0 selects idle) |
| stopWr | input | 1 | Write strobe for the stop bit |
| stopData | input | 1 | Stop value written |
| nmiReq | input | 1 | Non-maskable request |
| extReq | input | 7 | External request lines |
| extMask | input | 7 | External masks, 1 = masked |
| extPrio | input | 21 | External priorities, 3 bits per line, line n at bits 3n+2:3n |
| intReq | input | 4 | Internal peripheral requests |
| intMask | input | 4 | Internal masks, 1 = masked |
| intPrio | input | 12 | Internal priorities, 3 bits per request |
| inSvcValid | input | 1 | An interrupt is in service |
| inSvcPrio | input | 3 | Priority of the in-service interrupt |
| intEnable | input | 1 | Processor interrupt-enable flag |
| cpuClkEn | output | 1 | CPU clock enable |
| mainPeriClkEn | output | 1 | Main-clock peripheral enable |
| auxPeriClkEn | output | 1 | Always-on domain enable |
| idleActive | output | 1 | Block is in idle |
| actStrobe | output | 1 | Post-wake action valid |
| actCode | output | 2 | 0 none, 1 branch to handler, 2 next instruction |
| ackPulse | output | 1 | Waking request acknowledged |
| ackId | output | 4 | ID of the acknowledged source |

## Verification
Several properties are checked on every cycle. A qualifying stop write always arms the delay, and an ignored write always leaves the block in normal mode. A wake in idle always exits on the next edge, the settling window never drops back to normal, and a non-maskable wake is always acknowledged. Code and acknowledge stay quiet outside the strobe. The winner selection, the tie-break, the exact five-cycle count and the combination of in-service level and enable flag are shown only by the bench's scenarios. The same holds for the reset-in-idle case, where each expected action is queued and compared when it appears.

// File: rtl/idle_pkg.sv
package idle_pkg;
  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_BRANCH = 2'd1,
    ACT_NEXT   = 2'd2
  } act_e;

  typedef enum logic [1:0] {
    ST_NORMAL = 2'd0,
    ST_ARM    = 2'd1,
    ST_IDLE   = 2'd2
  } state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic inIdle;
  } ctl_s;
endpackage

// File: rtl/idle_ctrl.sv
module idle_ctrl
  import idle_pkg::*;
#(
  parameter int DELAY = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic modeSelWr,
  input  logic modeSelData,
  input  logic stopWr,
  input  logic stopData,
  input  logic wakeReq,
  output ctl_s ctl,
  output logic idleActive
);
  localparam int CNT_W = (DELAY < 2) ? 1 : $clog2(DELAY);

  state_e state;
  logic modeSel;
  logic [CNT_W-1:0] cnt;
  logic stopHit;

  assign stopHit = stopWr && stopData && !modeSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_NORMAL;
      modeSel <= 1'b0;
      cnt     <= '0;
    end else begin
      if (modeSelWr) modeSel <= modeSelData;
      unique case (state)
        ST_NORMAL: if (stopHit) begin
          state <= ST_ARM;
          cnt   <= CNT_W'(DELAY - 1);
        end
        ST_ARM: if (cnt == '0) state <= ST_IDLE;
                else cnt <= cnt - 1'b1;
        ST_IDLE: if (wakeReq) state <= ST_NORMAL;
        default: state <= ST_NORMAL;
      endcase
    end
  end

  assign ctl.capture = (state == ST_IDLE) && wakeReq;
  assign ctl.inIdle  = (state == ST_IDLE);
  assign idleActive  = (state == ST_IDLE);

  assert_enter_arm_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_NORMAL && stopWr && stopData && !modeSel) |=> state == ST_ARM);
  assert_ignore_stop_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_NORMAL && stopWr && (modeSel || !stopData)) |=> state == ST_NORMAL);
  assert_arm_holds_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ARM) |=> state != ST_NORMAL);
  assert_wake_exit_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && wakeReq) |=> state == ST_NORMAL);
  assert_idle_stays_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !wakeReq) |=> state == ST_IDLE);
endmodule

// File: rtl/idle_wake_dp.sv
module idle_wake_dp
  import idle_pkg::*;
#(
  parameter int NUM_EXT = 7,
  parameter int NUM_INT = 4,
  parameter int PRIO_W  = 3,
  parameter int ID_W    = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctl_s                      ctl,
  input  logic                      nmiReq,
  input  logic [NUM_EXT-1:0]        extReq,
  input  logic [NUM_EXT-1:0]        extMask,
  input  logic [NUM_EXT*PRIO_W-1:0] extPrio,
  input  logic [NUM_INT-1:0]        intReq,
  input  logic [NUM_INT-1:0]        intMask,
  input  logic [NUM_INT*PRIO_W-1:0] intPrio,
  input  logic                      inSvcValid,
  input  logic [PRIO_W-1:0]         inSvcPrio,
  input  logic                      intEnable,
  output logic                      wakeReq,
  output logic                      actStrobe,
  output act_e                      actCode,
  output logic                      ackPulse,
  output logic [ID_W-1:0]           ackId
);
  localparam int NUM_SRC = NUM_EXT + NUM_INT;
  localparam logic [ID_W-1:0] NMI_ID = '1;

  logic [NUM_SRC-1:0]        srcLive;
  logic [NUM_SRC*PRIO_W-1:0] srcPrio;
  logic                      found;
  logic [PRIO_W-1:0]         winPrio;
  logic [ID_W-1:0]           winId;
  logic                      doAck;
  act_e                      code;
  logic [ID_W-1:0]           id;

  assign srcLive = {intReq & ~intMask, extReq & ~extMask};
  assign srcPrio = {intPrio, extPrio};
  assign wakeReq = nmiReq || (|srcLive);

  // strict less-than keeps the lowest ID on a tie
  always_comb begin
    found   = 1'b0;
    winPrio = '1;
    winId   = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (srcLive[i] && (!found || srcPrio[i*PRIO_W +: PRIO_W] < winPrio)) begin
        found   = 1'b1;
        winPrio = srcPrio[i*PRIO_W +: PRIO_W];
        winId   = ID_W'(i);
      end
    end
  end

  always_comb begin
    if (nmiReq) begin
      doAck = 1'b1;
      code  = ACT_BRANCH;
      id    = NMI_ID;
    end else if (intEnable && (!inSvcValid || winPrio < inSvcPrio)) begin
      doAck = 1'b1;
      code  = ACT_BRANCH;
      id    = winId;
    end else begin
      doAck = 1'b0;
      code  = ACT_NEXT;
      id    = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actStrobe <= 1'b0;
      actCode   <= ACT_NONE;
      ackPulse  <= 1'b0;
      ackId     <= '0;
    end else begin
      actStrobe <= ctl.capture;
      actCode   <= ctl.capture ? code : ACT_NONE;
      ackPulse  <= ctl.capture && doAck;
      ackId     <= (ctl.capture && doAck) ? id : '0;
    end
  end

  assert_nmi_ack_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.capture && nmiReq) |=> ackPulse && ackId == NMI_ID && actCode == ACT_BRANCH);
  assert_di_next_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.capture && !nmiReq && !intEnable) |=> actCode == ACT_NEXT && !ackPulse);
  assert_held_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.capture && !nmiReq && inSvcValid && winPrio >= inSvcPrio) |=> actCode == ACT_NEXT && !ackPulse);
  assert_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !actStrobe |-> (actCode == ACT_NONE && !ackPulse && ackId == '0));
  assert_one_cycle_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.inIdle) |=> !actStrobe);
endmodule

// File: rtl/idle_standby.sv
module idle_standby
  import idle_pkg::*;
#(
  parameter int NUM_EXT = 7,
  parameter int NUM_INT = 4,
  parameter int PRIO_W  = 3,
  parameter int ID_W    = 4,
  parameter int DELAY   = 5
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      modeSelWr,
  input  logic                      modeSelData,
  input  logic                      stopWr,
  input  logic                      stopData,
  input  logic                      nmiReq,
  input  logic [NUM_EXT-1:0]        extReq,
  input  logic [NUM_EXT-1:0]        extMask,
  input  logic [NUM_EXT*PRIO_W-1:0] extPrio,
  input  logic [NUM_INT-1:0]        intReq,
  input  logic [NUM_INT-1:0]        intMask,
  input  logic [NUM_INT*PRIO_W-1:0] intPrio,
  input  logic                      inSvcValid,
  input  logic [PRIO_W-1:0]         inSvcPrio,
  input  logic                      intEnable,
  output logic                      cpuClkEn,
  output logic                      mainPeriClkEn,
  output logic                      auxPeriClkEn,
  output logic                      idleActive,
  output logic                      actStrobe,
  output logic [1:0]                actCode,
  output logic                      ackPulse,
  output logic [ID_W-1:0]           ackId
);
  ctl_s ctl;
  logic wakeReq;
  act_e code;

  idle_ctrl #(.DELAY(DELAY)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .modeSelWr(modeSelWr), .modeSelData(modeSelData),
    .stopWr(stopWr), .stopData(stopData),
    .wakeReq(wakeReq), .ctl(ctl), .idleActive(idleActive)
  );

  idle_wake_dp #(.NUM_EXT(NUM_EXT), .NUM_INT(NUM_INT), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .nmiReq(nmiReq), .extReq(extReq), .extMask(extMask), .extPrio(extPrio),
    .intReq(intReq), .intMask(intMask), .intPrio(intPrio),
    .inSvcValid(inSvcValid), .inSvcPrio(inSvcPrio), .intEnable(intEnable),
    .wakeReq(wakeReq), .actStrobe(actStrobe), .actCode(code),
    .ackPulse(ackPulse), .ackId(ackId)
  );

  assign actCode       = code;
  assign cpuClkEn      = !idleActive;
  assign mainPeriClkEn = !idleActive;
  assign auxPeriClkEn  = 1'b1;

  assert_strobe_after_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    actStrobe |-> (cpuClkEn && $past(idleActive)));
  assert_reset_enables_R12: assert property (@(posedge clk)
    !rstN |-> (cpuClkEn && mainPeriClkEn && !actStrobe));
endmodule

// File: tb/test_idle_standby.sv
`timescale 1ns/1ps
module test_idle_standby;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeSelWr = 0, modeSelData = 0, stopWr = 0, stopData = 0, nmiReq = 0;
  logic [6:0] extReq = '0, extMask = '0;
  logic [20:0] extPrio = '1;
  logic [3:0] intReq = '0, intMask = '0;
  logic [11:0] intPrio = '1;
  logic inSvcValid = 0, intEnable = 1;
  logic [2:0] inSvcPrio = 3'd7;
  logic cpuClkEn, mainPeriClkEn, auxPeriClkEn, idleActive, actStrobe, ackPulse;
  logic [1:0] actCode;
  logic [3:0] ackId;

  int nTests = 0, nFail = 0;
  logic [6:0] expQ[$];   // {code[1:0], ack, id[3:0]}

  always #4 clk = ~clk;

  idle_standby i_idle_standby (
    .clk(clk), .rstN(rstN), .modeSelWr(modeSelWr), .modeSelData(modeSelData),
    .stopWr(stopWr), .stopData(stopData), .nmiReq(nmiReq),
    .extReq(extReq), .extMask(extMask), .extPrio(extPrio),
    .intReq(intReq), .intMask(intMask), .intPrio(intPrio),
    .inSvcValid(inSvcValid), .inSvcPrio(inSvcPrio), .intEnable(intEnable),
    .cpuClkEn(cpuClkEn), .mainPeriClkEn(mainPeriClkEn), .auxPeriClkEn(auxPeriClkEn),
    .idleActive(idleActive), .actStrobe(actStrobe), .actCode(actCode),
    .ackPulse(ackPulse), .ackId(ackId)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pop the scoreboard on each strobe
  always @(negedge clk) begin
    if (rstN) begin
      chk(auxPeriClkEn, "R4 aux enable", auxPeriClkEn, 1);
      if (actStrobe) begin
        if (expQ.size() == 0) chk(0, "R5 unexpected strobe", 1, 0);
        else begin
          logic [6:0] e;
          e = expQ.pop_front();
          chk({actCode, ackPulse, ackId} == e, "R7/R8/R9/R10 action", {actCode, ackPulse, ackId}, e);
        end
      end else
        chk(actCode == 0 && !ackPulse && ackId == 0, "R11 quiet", {actCode, ackPulse, ackId}, 0);
    end
  end

  task automatic clearReqs();
    nmiReq = 0; extReq = '0; intReq = '0; extMask = '0; intMask = '0;
  endtask

  task automatic enterIdle(input bit timed);
    stopWr = 1; stopData = 1;
    @(negedge clk);
    stopWr = 0; stopData = 0;
    repeat (4) begin
      if (timed) chk(!idleActive && cpuClkEn, "R2 still running", idleActive, 0);
      @(negedge clk);
    end
    if (timed) chk(!idleActive && cpuClkEn, "R2 still running", idleActive, 0);
    @(negedge clk);
    chk(idleActive, "R2 idle after five", idleActive, 1);
    chk(!cpuClkEn && !mainPeriClkEn, "R2 gated", {cpuClkEn, mainPeriClkEn}, 0);
  endtask

  // caller has set requests just after a negedge
  task automatic doWake(input logic [1:0] code, input bit ack, input logic [3:0] id);
    expQ.push_back({code, ack, id});
    @(negedge clk);
    chk(cpuClkEn && mainPeriClkEn && !idleActive, "R6 woke", {cpuClkEn, mainPeriClkEn, idleActive}, 6);
    clearReqs();
    @(negedge clk);
    chk(!actStrobe, "R11 single strobe", actStrobe, 0);
  endtask

  initial begin
    #(8 * 200000);
    chk(0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #3;
    chk(cpuClkEn && mainPeriClkEn && !idleActive && !actStrobe && !ackPulse, "R1 reset", cpuClkEn, 1);
    repeat (2) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(cpuClkEn && mainPeriClkEn && !idleActive, "R1 after reset", idleActive, 0);

    // R2 exact entry timing, then masked request ignored (R6)
    enterIdle(1);
    extReq[3] = 1; extMask[3] = 1; intReq[2] = 1; intMask[2] = 1;
    repeat (3) @(negedge clk);
    chk(idleActive && !cpuClkEn, "R6 masked ignored", idleActive, 1);
    clearReqs();
    // R8 simple wake, ext line 2
    extPrio[2*3 +: 3] = 3'd3; extReq[2] = 1;
    doWake(2'd1, 1, 4'd2);

    // R3 mode bit 1 blocks stop
    modeSelWr = 1; modeSelData = 1; @(negedge clk); modeSelWr = 0;
    stopWr = 1; stopData = 1; @(negedge clk); stopWr = 0; stopData = 0;
    repeat (7) @(negedge clk);
    chk(!idleActive && cpuClkEn, "R3 mode bit blocks", idleActive, 0);
    modeSelWr = 1; modeSelData = 0; @(negedge clk); modeSelWr = 0;
    // R3 stop value 0 ignored
    stopWr = 1; stopData = 0; @(negedge clk); stopWr = 0;
    repeat (7) @(negedge clk);
    chk(!idleActive, "R3 zero write ignored", idleActive, 0);

    // R5 request during settling window
    stopWr = 1; stopData = 1; @(negedge clk); stopWr = 0; stopData = 0;
    extReq[1] = 1; @(negedge clk); extReq = '0;
    repeat (3) @(negedge clk);
    chk(!idleActive, "R5 settling", idleActive, 0);
    @(negedge clk);
    chk(idleActive, "R5 idle reached", idleActive, 1);
    // R8 tie-break: ext4 prio1, int1 (id 8) prio1, ext0 prio5
    extPrio = '1; intPrio = '1;
    extPrio[4*3 +: 3] = 3'd1; extPrio[0 +: 3] = 3'd5; intPrio[1*3 +: 3] = 3'd1;
    extReq[4] = 1; extReq[0] = 1; intReq[1] = 1;
    doWake(2'd1, 1, 4'd4);
    // R8 internal winner
    enterIdle(0);
    intPrio[3*3 +: 3] = 3'd0; intReq[3] = 1; extReq[0] = 1;
    doWake(2'd1, 1, 4'd10);

    // R9 interrupts disabled
    enterIdle(0);
    intEnable = 0; extReq[1] = 1;
    doWake(2'd2, 0, 4'd0);
    intEnable = 1;

    // R10 in service at level 2
    inSvcValid = 1; inSvcPrio = 3'd2;
    enterIdle(0);
    extPrio[5*3 +: 3] = 3'd4; extReq[5] = 1;
    doWake(2'd2, 0, 4'd0);
    enterIdle(0);
    extPrio[5*3 +: 3] = 3'd2; extReq[5] = 1;
    doWake(2'd2, 0, 4'd0);
    enterIdle(0);
    extPrio[5*3 +: 3] = 3'd1; extReq[5] = 1;
    doWake(2'd1, 1, 4'd5);

    // R7 NMI with DI and in-service level 0
    inSvcPrio = 3'd0; intEnable = 0;
    enterIdle(0);
    nmiReq = 1; extReq[6] = 1;
    doWake(2'd1, 1, 4'd15);
    inSvcValid = 0; intEnable = 1;

    // R12 reset while idle
    enterIdle(0);
    #2 rstN = 0;
    #1 chk(cpuClkEn && mainPeriClkEn && !idleActive, "R12 async reset", cpuClkEn, 1);
    @(negedge clk); rstN = 1;
    @(negedge clk);
    chk(expQ.size() == 0, "R11 all strobes seen", expQ.size(), 0);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule